// File: doc/BRIEF.md
# Rank Refresh Sequencer

This block schedules periodic all-bank refresh for a single DRAM rank. A refresh deadline advances by a fixed interval. The sequencer starts working on a refresh one precharge time before that deadline, so that it has room to close open rows first. It waits for outstanding traffic on the rank to drain. If the rank is in a low-power state, it asks for a wake-up and allows the exit delay to elapse. It then closes all banks with one precharge-all when any bank is open, and issues the refresh. While a refresh runs, it holds off activates until the refresh is complete.

The surrounding controller supplies the current cycle number, the count of open banks, the earliest cycle at which each bank may be precharged, a busy flag for traffic in flight, and a low-power flag. The sequencer returns the following:
- command strobes, each stamped with its issue cycle;
- a wake-up request with the cycle at which the exit delay ends;
- the cycle before which no activate may be issued;
- a one-cycle completion pulse;
- a sticky flag that is raised when refresh has fallen so far behind that it can no longer catch up.

The configuration requires the refresh interval to be longer than both the precharge time and the refresh time. This is checked when the design is elaborated.

Top module: `rank_refresh_seq`

## Requirements
- R1: After reset every strobe (prea_o, ref_o, wake_o, done_o) and overrun_o is 0, and act_block_until_o is 0.
- R2: The refresh deadline resets to T_REFI and advances by T_REFI on every refresh issued. The sequencer leaves idle at the first clock where now_i is at least the deadline minus T_RP. Each state step takes one clock, so an uncontended refresh (not busy, not low power, no open bank) is issued when now_i equals that cycle plus 3.
- R3: While busy_i is high, the sequencer waits for traffic to drain and issues no command. It moves on at the first clock that sees busy_i low.
- R4: If active_banks_i is nonzero in the precharge step, the sequencer pulses prea_o for one clock. prea_at_o is the maximum of now_i and every bank's slot of pre_allowed_at_i, and act_block_until_o becomes prea_at_o + T_RP. Bank g occupies bits [g*TW +: TW].
- R5: If active_banks_i is zero in the precharge step, no precharge-all is issued, and refresh may start on the next clock.
- R6: The refresh is issued at the first clock, after the precharge step, at which now_i has reached the precharge-all cycle + T_RP and active_banks_i is zero. At that clock ref_o pulses, ref_at_o equals now_i, and act_block_until_o becomes now_i + T_RFC.
- R7: If low_power_i is high when draining ends, wake_o pulses for one clock and wake_at_o is now_i + T_XP. The precharge step follows on the clock after now_i reaches wake_at_o.
- R8: overrun_o is set when a refresh is issued and the advanced deadline is strictly less than that refresh's completion cycle. It is not set when the two are equal. Once set, it stays set until reset.
- R9: done_o pulses for exactly one clock at the first clock where now_i reaches the completion cycle, and the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| now_i | input | TW | Current cycle number |
| active_banks_i | input | $clog2(NB+1) | Number of open banks in the rank |
| pre_allowed_at_i | input | NB*TW | Earliest precharge cycle for each bank, bank g in slot g |
| busy_i | input | 1 | Traffic to this rank still in flight |
| low_power_i | input | 1 | Rank is in a low-power state |
| prea_o | output | 1 | Precharge-all strobe |
| prea_at_o | output | TW | Issue cycle of the precharge-all |
| ref_o | output | 1 | Refresh strobe |
| ref_at_o | output | TW | Issue cycle of the refresh |
| wake_o | output | 1 | Wake-up request strobe |
| wake_at_o | output | TW | Cycle at which the exit delay ends |
| act_block_until_o | output | TW | No activate before this cycle |
| done_o | output | 1 | Refresh completed, one-clock pulse |
| overrun_o | output | 1 | Sticky flag: refresh can no longer catch up |

## Verification
The assertions assume the following about the inputs:
- now_i rises by exactly one per clock from reset and never wraps.
- active_banks_i drops to zero only after the banks have actually closed.
- low_power_i is meaningful when draining ends.

The bench drives now_i as a free-running counter, so its runs stay far below the wrap point. It derives the busy, open-bank and low-power inputs as functions of that counter, so each input changes at a cycle the bench chooses. The stimulus sweeps which bank holds the latest precharge time, whether that time is in the past or the future, and when the banks close. It also runs drain and wake-up delays, both separately and combined, and places completion exactly on the next deadline and one cycle past it.

// File: rtl/rfs_pkg.sv
`timescale 1ns/1ps
package rfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_PD_EXIT = 3'd2,
    ST_PRE     = 3'd3,
    ST_START   = 3'd4,
    ST_RUN     = 3'd5
  } rfs_state_e;
endpackage

// File: rtl/rfs_max_tree.sv
`timescale 1ns/1ps
// Balanced maximum over N packed W-bit values.
module rfs_max_tree #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 32
) (
  input  logic [N*W-1:0] vals_i,
  output logic [W-1:0]   max_o
);
  localparam int unsigned LVL = (N > 1) ? $clog2(N) : 0;
  localparam int unsigned P   = 1 << LVL;

  logic [W-1:0] node [1:2*P-1];

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < N) begin : g_in
      assign node[P+i] = vals_i[i*W +: W];
    end else begin : g_pad
      assign node[P+i] = '0;
    end
  end

  for (genvar k = 1; k < P; k++) begin : g_node
    assign node[k] = (node[2*k] > node[2*k+1]) ? node[2*k] : node[2*k+1];
  end

  assign max_o = node[1];
endmodule

// File: rtl/rfs_due_track.sv
`timescale 1ns/1ps
// Refresh deadline, early event time and catch-up check.
module rfs_due_track #(
  parameter int unsigned TW     = 32,
  parameter int unsigned T_RP   = 14,
  parameter int unsigned T_REFI = 6240
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [TW-1:0] done_at_i,
  output logic [TW-1:0] event_at_o,
  output logic          overrun_o
);
  localparam logic [TW-1:0] REFI_W = TW'(T_REFI);
  localparam logic [TW-1:0] RP_W   = TW'(T_RP);

  logic [TW-1:0] due_q, due_nxt;
  logic          ovr_q;

  assign due_nxt    = due_q + REFI_W;
  assign event_at_o = due_q - RP_W;  // leaves room for a precharge-all
  assign overrun_o  = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      due_q <= REFI_W;
      ovr_q <= 1'b0;
    end else if (adv_i) begin
      due_q <= due_nxt;
      if (due_nxt < done_at_i) ovr_q <= 1'b1;
    end
  end

  assert_overrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
  assert_deadline_moves_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> event_at_o > $past(event_at_o));
endmodule

// File: rtl/rank_refresh_seq.sv
`timescale 1ns/1ps
module rank_refresh_seq
  import rfs_pkg::*;
#(
  parameter int unsigned NB     = 8,
  parameter int unsigned TW     = 32,
  parameter int unsigned T_RP   = 14,
  parameter int unsigned T_RFC  = 280,
  parameter int unsigned T_REFI = 6240,
  parameter int unsigned T_XP   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [TW-1:0]              now_i,
  input  logic [$clog2(NB+1)-1:0]    active_banks_i,
  input  logic [NB*TW-1:0]           pre_allowed_at_i,
  input  logic                       busy_i,
  input  logic                       low_power_i,
  output logic                       prea_o,
  output logic [TW-1:0]              prea_at_o,
  output logic                       ref_o,
  output logic [TW-1:0]              ref_at_o,
  output logic                       wake_o,
  output logic [TW-1:0]              wake_at_o,
  output logic [TW-1:0]              act_block_until_o,
  output logic                       done_o,
  output logic                       overrun_o
);
  localparam int unsigned   CW    = $clog2(NB+1);
  localparam logic [TW-1:0] RP_W  = TW'(T_RP);
  localparam logic [TW-1:0] RFC_W = TW'(T_RFC);
  localparam logic [TW-1:0] XP_W  = TW'(T_XP);

  if (!(T_REFI > T_RP && T_REFI > T_RFC)) begin : g_cfg_bad
    $error("refresh interval must exceed both precharge and refresh time");
  end

  rfs_state_e    state_q;
  logic [TW-1:0] wait_q;      // shared deadline: wake end, refresh start, refresh end
  logic [TW-1:0] pre_max, pre_at, ref_end, event_at;
  logic          banks_open, due_hit, start_go, adv;
  logic          prea_q, ref_q, wake_q, done_q;
  logic [TW-1:0] prea_at_q, ref_at_q, wake_at_q, blk_q;

  rfs_max_tree #(.N(NB), .W(TW)) u_max (
    .vals_i (pre_allowed_at_i),
    .max_o  (pre_max)
  );

  rfs_due_track #(.TW(TW), .T_RP(T_RP), .T_REFI(T_REFI)) u_due (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .done_at_i  (ref_end),
    .event_at_o (event_at),
    .overrun_o  (overrun_o)
  );

  assign banks_open = (active_banks_i != CW'(0));
  assign pre_at     = (pre_max > now_i) ? pre_max : now_i;
  assign ref_end    = now_i + RFC_W;
  assign due_hit    = (now_i >= event_at);
  assign start_go   = (now_i >= wait_q) && !banks_open;
  assign adv        = (state_q == ST_START) && start_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      wait_q    <= '0;
      prea_q    <= 1'b0;
      prea_at_q <= '0;
      ref_q     <= 1'b0;
      ref_at_q  <= '0;
      wake_q    <= 1'b0;
      wake_at_q <= '0;
      blk_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      prea_q <= 1'b0;
      ref_q  <= 1'b0;
      wake_q <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (due_hit) state_q <= ST_DRAIN;
        ST_DRAIN: begin
          if (!busy_i) begin
            if (low_power_i) begin
              wake_q    <= 1'b1;
              wake_at_q <= now_i + XP_W;
              wait_q    <= now_i + XP_W;
              state_q   <= ST_PD_EXIT;
            end else begin
              state_q <= ST_PRE;
            end
          end
        end
        ST_PD_EXIT: if (now_i >= wait_q) state_q <= ST_PRE;
        ST_PRE: begin
          if (banks_open) begin
            prea_q    <= 1'b1;
            prea_at_q <= pre_at;
            blk_q     <= pre_at + RP_W;
            wait_q    <= pre_at + RP_W;
          end else begin
            wait_q <= now_i;
          end
          state_q <= ST_START;
        end
        ST_START: begin
          if (start_go) begin
            ref_q    <= 1'b1;
            ref_at_q <= now_i;
            blk_q    <= ref_end;
            wait_q   <= ref_end;
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (now_i >= wait_q) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign prea_o            = prea_q;
  assign prea_at_o         = prea_at_q;
  assign ref_o             = ref_q;
  assign ref_at_o          = ref_at_q;
  assign wake_o            = wake_q;
  assign wake_at_o         = wake_at_q;
  assign act_block_until_o = blk_q;
  assign done_o            = done_q;

  assert_strobes_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prea_o, ref_o, wake_o, done_o}));
  assert_prea_not_early_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prea_o |-> prea_at_o >= $past(now_i));
  for (genvar g = 0; g < NB; g++) begin : g_pa_chk
    assert_prea_covers_bank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prea_o |-> prea_at_o >= $past(pre_allowed_at_i[g*TW +: TW]));
  end
  assert_ref_banks_closed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |-> $past(active_banks_i) == CW'(0));
  assert_ref_after_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |-> $past(now_i) >= $past(act_block_until_o));
  assert_wake_needs_lp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(low_power_i));
  assert_done_not_early_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(now_i) >= $past(act_block_until_o));
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/tb_rank_refresh_seq.sv
`timescale 1ns/1ps
module tb_rank_refresh_seq;
  localparam int NB = 4, TW = 16, T_RP = 3, T_RFC = 8, T_REFI = 50, T_XP = 4;
  localparam int CW = $clog2(NB+1);

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic                rst_n;
  logic [TW-1:0]       now;
  logic [CW-1:0]       active;
  logic [NB*TW-1:0]    pa_flat;
  logic                busy, lp;
  logic                prea_o, ref_o, wake_o, done_o, overrun_o;
  logic [TW-1:0]       prea_at_o, ref_at_o, wake_at_o, act_blk;

  rank_refresh_seq #(.NB(NB), .TW(TW), .T_RP(T_RP), .T_RFC(T_RFC),
                     .T_REFI(T_REFI), .T_XP(T_XP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .now_i(now), .active_banks_i(active),
    .pre_allowed_at_i(pa_flat), .busy_i(busy), .low_power_i(lp),
    .prea_o(prea_o), .prea_at_o(prea_at_o), .ref_o(ref_o), .ref_at_o(ref_at_o),
    .wake_o(wake_o), .wake_at_o(wake_at_o), .act_block_until_o(act_blk),
    .done_o(done_o), .overrun_o(overrun_o)
  );

  int  n_chk = 0, n_fail = 0;
  bit  finished = 0;
  int  busy_until = 0, close_at = 0, n_open = 0;
  bit  lp_on = 0;
  bit  prea_seen, ref_seen, wake_seen, done_seen;
  int  prea_at_s, blk_prea, ref_now, ref_at_s, blk_ref, wake_now, wake_at_s, done_now;
  int  due = T_REFI, prev_done = -1;
  bit  ovf_exp = 0;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply_inputs();
    busy   = (int'(now) < busy_until);
    active = (int'(now) < close_at) ? CW'(n_open) : '0;
    lp     = lp_on;
  endtask

  task automatic tick();
    @(negedge clk);
    if (prea_o) begin prea_seen = 1; prea_at_s = int'(prea_at_o); blk_prea = int'(act_blk); end
    if (ref_o)  begin ref_seen = 1; ref_now = int'(now); ref_at_s = int'(ref_at_o); blk_ref = int'(act_blk); end
    if (wake_o) begin wake_seen = 1; wake_now = int'(now); wake_at_s = int'(wake_at_o); end
    if (done_o) begin done_seen = 1; done_now = int'(now); end
    now = now + 1'b1;
    apply_inputs();
  endtask

  function automatic int next_event();
    return imax(due - T_RP, prev_done + 1);
  endfunction

  // n open banks; hot bank gets P+hot_rel, others P+base_rel; drain for busy_rel
  // cycles past the event; banks close at P+close_rel.
  task automatic do_ref(int n, int hot, int hot_rel, int base_rel, int busy_rel,
                        bit lpv, int close_rel);
    int e, x, p, pm, pat, s, k, r, dn;
    e = next_event();
    x = imax(e + 1, e + busy_rel);
    p = lpv ? x + T_XP + 1 : x + 1;
    pm = 0;
    for (int j = 0; j < NB; j++) begin
      int v;
      v = (j == hot) ? p + hot_rel : p + base_rel;
      if (v < 0) v = 0;
      pa_flat[j*TW +: TW] = TW'(v);
      pm = imax(pm, v);
    end
    pat = imax(p, pm);
    s   = (n > 0) ? pat + T_RP : p;
    k   = (n > 0) ? p + close_rel : 0;
    r   = imax(imax(p + 1, s), k);
    dn  = r + T_RFC;
    due = due + T_REFI;
    if (due < dn) ovf_exp = 1;
    busy_until = e + busy_rel; close_at = k; n_open = n; lp_on = lpv;
    apply_inputs();
    prea_seen = 0; ref_seen = 0; wake_seen = 0; done_seen = 0;
    for (int t = 0; t < 3000 && !done_seen; t++) tick();
    chk("R9", "done seen", int'(done_seen), 1);
    chk("R2", "refresh seen", int'(ref_seen), 1);
    chk("R6", "refresh cycle", ref_now, r);
    chk("R6", "ref_at_o", ref_at_s, r);
    chk("R6", "block after refresh", blk_ref, r + T_RFC);
    chk("R9", "done cycle", done_now, dn);
    chk("R5", "prea presence", int'(prea_seen), int'(n > 0));
    if (n > 0) begin
      chk("R4", "prea_at_o", prea_at_s, pat);
      chk("R4", "block after prea", blk_prea, s);
    end
    chk("R7", "wake presence", int'(wake_seen), int'(lpv));
    if (lpv) begin
      chk("R7", "wake cycle", wake_now, x);
      chk("R7", "wake_at_o", wake_at_s, x + T_XP);
    end
    chk("R3", "drain end before command", int'(!ref_seen || ref_now > e + busy_rel), 1);
    chk("R8", "overrun", int'(overrun_o), int'(ovf_exp));
    prev_done = dn;
    tick();
    chk("R9", "done single pulse", int'(done_seen && !done_o), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int br;
    rst_n = 1'b0; now = '0; pa_flat = '0; apply_inputs();
    repeat (3) tick();
    chk("R1", "prea_o", int'(prea_o), 0);
    chk("R1", "ref_o", int'(ref_o), 0);
    chk("R1", "wake_o", int'(wake_o), 0);
    chk("R1", "done_o", int'(done_o), 0);
    chk("R1", "overrun_o", int'(overrun_o), 0);
    chk("R1", "act_block_until_o", int'(act_blk), 0);
    rst_n = 1'b1;
    do_ref(0, 0, 0, 0, 0, 0, 1);                 // R2 plain
    for (int h = 0; h < NB; h++)                 // R4 latest bank sweep
      do_ref(2, h, 7, -4, 0, 0, 5);
    do_ref(3, 1, -1, -6, 0, 0, 2);               // R4 all in the past
    do_ref(1, 2, 0, 0, 0, 0, 20);                // R6 late close
    do_ref(0, 0, 0, 0, 15, 0, 1);                // R3 drain
    do_ref(0, 0, 0, 0, 0, 1, 1);                 // R7 wake
    do_ref(2, 3, 4, 0, 9, 1, 3);                 // combined
    br = due + T_REFI - T_RFC - 2 - next_event();
    do_ref(0, 0, 0, 0, br, 0, 1);                // R8 equality: no overrun
    br = due + T_REFI - T_RFC - 2 - next_event() + 1;
    do_ref(0, 0, 0, 0, br, 0, 1);                // R8 overrun
    do_ref(0, 0, 0, 0, 0, 0, 1);                 // R8 stays set
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule